// File: doc/BRIEF.md
# Masked Color Key Write Filter

This block sits in the pixel write path of a rectangle block-transfer engine. For every pixel it gets two values: the source pixel that would be written and the value the destination currently holds. It decides whether that write is committed. One of the two operands is compared against a programmable key color. A per-bit mask chooses which bits take part in the comparison. When the masked bits all agree with the key, the write is suppressed.

Keying on the source gives transparent transfers. The sprite's key-colored background is skipped, so an irregular shape can be drawn with a plain rectangle fill. Keying on the destination protects screen regions already painted in the key color. Clearing mask bits widens the key from a single value to a range of colors.

Configuration registers hold the key, the mask, the operand select and the enable. The engine raises `busy` while a transfer runs, and register writes are refused during that time. The pixel path has one registered stage with ready/valid flow control. The pixel leaves with a write-enable attached.

Top module: `ckey_filter`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and keying is disabled, so the first pixels are written.
- R2: A pixel accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_valid`/`out_data` right after that edge. `out_data` equals the source pixel.
- R3: With keying disabled, every accepted pixel leaves with `out_we` = 1, whatever its source and destination values.
- R4: With keying enabled and select = source, `out_we` is 0 exactly when the source pixel matches the key.
- R5: With keying enabled and select = destination, `out_we` is 0 exactly when the destination pixel matches the key, regardless of the source value.
- R6: A match means ((operand XOR key) AND mask) == 0. Mask bits at 0 are ignored, so a mask of all zeros matches every pixel.
- R7: Register map, written via `cfg_we`/`cfg_addr`/`cfg_wdata`: address 0 is the key, address 1 is the mask, address 2 is control. In control, bit 0 is enable and bit 1 is select (0 = source, 1 = destination). A write takes effect for pixels accepted after the write edge.
- R8: A register write presented while `busy` is 1 is ignored. The previous key, mask and control stay in force.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data`/`out_we` hold steady. A pixel offered during the stall is taken once the stall releases.
- R10: Reset values are key = 0, mask = all ones and select = source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | PIX_W | Register write data |
| busy | input | 1 | Transfer active; blocks register writes |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel |
| in_src | input | PIX_W | Source pixel value |
| in_dst | input | PIX_W | Current destination pixel value |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_data | output | PIX_W | Pixel to write (source value) |
| out_we | output | 1 | Commit the write when 1 |

## Verification
The bench offers pixels whose source matches the key while the destination does not, and the reverse. A design that wires the select backwards suppresses the wrong writes. A masked key is tested with values that differ only in ignored bits and with values that differ in one compared bit. A design that ignores the mask, or inverts its meaning, gets one of these two cases wrong. A key write attempted during `busy` must leave the old key active. A design that lets it through changes which pixels are written. A stall with a second pixel waiting exposes any stage that overwrites or drops the held output.

// File: rtl/ckey_pkg.sv
package ckey_pkg;
  typedef enum logic {
    KEY_ON_SRC = 1'b0,
    KEY_ON_DST = 1'b1
  } key_sel_e;

  localparam logic [1:0] REG_KEY  = 2'd0;
  localparam logic [1:0] REG_MASK = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
endpackage

// File: rtl/ckey_cfg.sv
module ckey_cfg
  import ckey_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [PIX_W-1:0] cfg_wdata,
  input  logic             busy,
  output logic [PIX_W-1:0] key_o,
  output logic [PIX_W-1:0] mask_o,
  output logic             en_o,
  output key_sel_e         sel_o
);
  logic wr_ok;
  assign wr_ok = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_o  <= '0;
      mask_o <= '1;
      en_o   <= 1'b0;
      sel_o  <= KEY_ON_SRC;
    end else if (wr_ok) begin
      case (cfg_addr)
        REG_KEY:  key_o  <= cfg_wdata;
        REG_MASK: mask_o <= cfg_wdata;
        REG_CTRL: begin
          en_o  <= cfg_wdata[0];
          sel_o <= key_sel_e'(cfg_wdata[1]);
        end
        default: ;
      endcase
    end
  end

  // R8
  cfg_frozen_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(key_o) && $stable(mask_o) && $stable(en_o) && $stable(sel_o)));
endmodule

// File: rtl/ckey_match.sv
module ckey_match #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] operand,
  input  logic [PIX_W-1:0] key,
  input  logic [PIX_W-1:0] mask,
  output logic             hit
);
  logic [PIX_W-1:0] bit_ok;

  for (genvar i = 0; i < PIX_W; i++) begin : g_bit
    assign bit_ok[i] = !mask[i] || (operand[i] == key[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/ckey_stage.sv
module ckey_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             we_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_we
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_we    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      out_data  <= pix_in;
      out_we    <= in_valid && we_in;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_we)));

  // R2
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_we |-> out_valid);
endmodule

// File: rtl/ckey_filter.sv
module ckey_filter
  import ckey_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [PIX_W-1:0] cfg_wdata,
  input  logic             busy,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_src,
  input  logic [PIX_W-1:0] in_dst,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_we
);
  logic [PIX_W-1:0] key, mask, operand;
  logic             en, hit, we_next;
  key_sel_e         sel;

  ckey_cfg #(.PIX_W(PIX_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy),
    .key_o(key), .mask_o(mask), .en_o(en), .sel_o(sel)
  );

  assign operand = (sel == KEY_ON_DST) ? in_dst : in_src;

  ckey_match #(.PIX_W(PIX_W)) u_match (
    .operand(operand), .key(key), .mask(mask), .hit(hit)
  );

  assign we_next = !(en && hit);

  ckey_stage #(.PIX_W(PIX_W)) u_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .pix_in(in_src), .we_in(we_next), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_we(out_we)
  );

  // R3
  disabled_writes_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !en) |=> out_we);

  // R6
  zero_mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && en && mask == '0) |=> (out_valid && !out_we));

  // R2
  src_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_src)));
endmodule

// File: tb/ckey_filter_tb.sv
module ckey_filter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic         busy = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_src = '0;
  logic [W-1:0] in_dst = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic         out_we;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  ckey_filter #(.PIX_W(W)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .in_valid(in_valid),
    .in_ready(in_ready), .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_we(out_we)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Sends one pixel and checks the outputs one edge later.
  task automatic send(string req, logic [W-1:0] s, logic [W-1:0] d, logic exp_we);
    @(negedge clk);
    in_valid = 1'b1; in_src = s; in_dst = d;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " data"}, 32'(out_data), 32'(s));
    check({req, " we"}, 32'(out_we), 32'(exp_we));
  endtask

  task automatic t_reset;
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    check("R1 in_ready after reset", 32'(in_ready), 32'd1);
    send("R1 R3 disabled after reset", 8'h00, 8'h00, 1'b1);
    send("R3 disabled any value", 8'h5A, 8'h5A, 1'b1);
  endtask

  task automatic t_defaults;
    reg_write(2'd2, 8'h01);
    send("R10 default key 0 mask ones", 8'h00, 8'hFF, 1'b0);
    send("R10 default key no match", 8'h01, 8'h00, 1'b1);
  endtask

  task automatic t_src_key;
    reg_write(2'd0, 8'h3C);
    reg_write(2'd1, 8'hFF);
    reg_write(2'd2, 8'h01);
    send("R4 src match skipped", 8'h3C, 8'h00, 1'b0);
    send("R4 src mismatch written", 8'h3D, 8'h3C, 1'b1);
    send("R2 R7 data is source", 8'hC3, 8'h11, 1'b1);
  endtask

  task automatic t_dst_key;
    reg_write(2'd2, 8'h03);
    send("R5 dst match protects", 8'h77, 8'h3C, 1'b0);
    send("R5 src match ignored", 8'h3C, 8'h00, 1'b1);
  endtask

  task automatic t_mask;
    reg_write(2'd0, 8'hA0);
    reg_write(2'd1, 8'hF0);
    reg_write(2'd2, 8'h01);
    send("R6 masked low bits ignored", 8'hA7, 8'h00, 1'b0);
    send("R6 compared bit differs", 8'hB0, 8'h00, 1'b1);
    reg_write(2'd1, 8'h00);
    send("R6 zero mask matches all", 8'h12, 8'h34, 1'b0);
  endtask

  task automatic t_busy;
    reg_write(2'd1, 8'hFF);
    reg_write(2'd0, 8'h55);
    @(negedge clk);
    busy = 1'b1;
    reg_write(2'd0, 8'h66);
    reg_write(2'd2, 8'h00);
    @(negedge clk);
    busy = 1'b0;
    send("R8 old key still active", 8'h55, 8'h00, 1'b0);
    send("R8 blocked key not used", 8'h66, 8'h00, 1'b1);
  endtask

  task automatic t_stall;
    reg_write(2'd2, 8'h00);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_src = 8'hA1; in_dst = 8'h00;
    @(negedge clk);
    in_src = 8'hB2;
    check("R9 stalled valid", 32'(out_valid), 32'd1);
    check("R9 in_ready low", 32'(in_ready), 32'd0);
    @(negedge clk);
    check("R9 held data", 32'(out_data), 32'hA1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 waiting pixel taken", 32'(out_data), 32'hB2);
    check("R9 waiting pixel valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R9 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_src_key();
    t_dst_key();
    t_mask();
    t_busy();
    t_stall();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule